// File: doc/BRIEF.md
# Region-Aware Five-Requester RAM Arbiter

This block decides, every clock, which requesters may access an internal RAM. Three masters sit on the main bus: a debug port, a DMA engine and the CPU. Two write-only transfer engines, A and B, reach the same RAM over a separate write path. The main bus and the separate path normally run side by side. Each path carries one access per cycle.

The RAM is split into 16 KB regions, and a region is selected by the address bits from REGION_W upwards. The two groups collide only when the main-bus winner and an engine target the same region in the same cycle. The fixed priority order then decides: debug, DMA, CPU, engine A, engine B. An engine therefore never beats a main-bus master. A request that loses is told to wait. It keeps its request and address steady until it is granted.

Grants come from registers. A request seen in one cycle is granted in the next cycle, for exactly one cycle. The requester holds its request through that grant cycle and then drops it or presents a new one. The arbiter does not grant a requester in the cycle straight after its grant, so the request still held during the grant cycle is not granted a second time. Two state machines hold the current grant. The main-bus machine has the states MB_IDLE, MB_DBG, MB_DMA and MB_CPU. The write-path machine has the states DP_IDLE, DP_ENGA and DP_ENGB. From any state, each machine moves to the state of the highest-priority eligible requester, or back to idle when none is eligible.

Top module: `ram_region_arb`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset before any request, every grant and wait output is 0.
- R2: On the main bus the highest-priority eligible requester is granted. The bit order is 0 = debug, 1 = DMA, 2 = CPU, and the priority order is debug, then DMA, then CPU.
- R3: An engine write and a main-bus grant are given in the same cycle when their addresses lie in different regions.
- R4: When the main-bus winner and an engine target the same region, the main-bus master is granted and the engine is not.
- R5: Between the engines (bit 0 = A, bit 1 = B), A has priority. B is granted when A is blocked by a region clash and B is not blocked.
- R6: A grant is asserted in the cycle after the request cycle and lasts one cycle. A request still held during its grant cycle is not granted again in the following cycle.
- R7: A wait bit is asserted in the cycle after a requester lost arbitration. It is never asserted for an uncontested request or during that requester's own grant cycle.
- R8: The region of an address is addr[ADDR_W-1:REGION_W]. Addresses that differ only below bit REGION_W clash; addresses that differ at bit REGION_W or above do not.
- R9: The main-bus grants are one-hot or zero, and the engine grants are one-hot or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_req | input | 3 | Main-bus requests (0 debug, 1 DMA, 2 CPU) |
| m_addr | input | 3*ADDR_W | Main-bus addresses; slot i at [i*ADDR_W +: ADDR_W] |
| m_gnt | output | 3 | Main-bus grants, registered |
| m_wait | output | 3 | Main-bus wait indications, registered |
| e_req | input | 2 | Engine write requests (0 A, 1 B) |
| e_addr | input | 2*ADDR_W | Engine write addresses; slot j at [j*ADDR_W +: ADDR_W] |
| e_gnt | output | 2 | Engine grants, registered |
| e_wait | output | 2 | Engine wait indications, registered |

## Verification
The hardest case to reach from the ports is engine B being granted while engine A is blocked. This needs A to clash with the main-bus winner in one region while B points at another region, all in the same cycle. A directed sequence sets up exactly this case. A second directed sequence places two addresses on either side of a region boundary and two addresses in the same region with different low bits. A long random phase then draws all addresses from two regions, so clashes and requests held across several cycles are frequent. In every cycle the grants and waits are compared with a behavioural priority model.

// File: rtl/ram_arb_pkg.sv
package ram_arb_pkg;

    localparam int NUM_MAIN = 3;
    localparam int NUM_ENG  = 2;

    localparam int MAIN_DBG = 0;
    localparam int MAIN_DMA = 1;
    localparam int MAIN_CPU = 2;
    localparam int ENG_A    = 0;
    localparam int ENG_B    = 1;

    typedef enum logic [1:0] {
        MB_IDLE,
        MB_DBG,
        MB_DMA,
        MB_CPU
    } mb_state_t;

    typedef enum logic [1:0] {
        DP_IDLE,
        DP_ENGA,
        DP_ENGB
    } dp_state_t;

    function automatic logic [NUM_MAIN-1:0] mb_decode(mb_state_t s);
        logic [NUM_MAIN-1:0] v;
        v = '0;
        unique case (s)
            MB_IDLE: v = '0;
            MB_DBG:  v[MAIN_DBG] = 1'b1;
            MB_DMA:  v[MAIN_DMA] = 1'b1;
            MB_CPU:  v[MAIN_CPU] = 1'b1;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [NUM_ENG-1:0] dp_decode(dp_state_t s);
        logic [NUM_ENG-1:0] v;
        v = '0;
        unique case (s)
            DP_IDLE: v = '0;
            DP_ENGA: v[ENG_A] = 1'b1;
            DP_ENGB: v[ENG_B] = 1'b1;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ram_region_cmp.sv
module ram_region_cmp #(
    parameter int ADDR_W   = 18,
    parameter int REGION_W = 14
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same
);
    logic [ADDR_W-1:0] diff;

    // Bits below REGION_W are shifted away; only region bits are compared.
    assign diff = (addr_a ^ addr_b) >> REGION_W;
    assign same = (diff == '0);
endmodule

// File: rtl/ram_main_fsm.sv
module ram_main_fsm
    import ram_arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_MAIN-1:0] req,
    output logic [NUM_MAIN-1:0] win,
    output logic [NUM_MAIN-1:0] gnt,
    output logic [NUM_MAIN-1:0] wait_o
);
    mb_state_t           state_q, state_d;
    logic [NUM_MAIN-1:0] elig;
    logic [NUM_MAIN-1:0] wait_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MB_IDLE;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            wait_q  <= req & ~gnt & ~win;
        end
    end

    // Next state: the requester granted in this cycle is masked
    always_comb begin
        elig = req & ~gnt;
        unique case (state_q)
            MB_IDLE, MB_DBG, MB_DMA, MB_CPU: begin
                if (elig[MAIN_DBG])      state_d = MB_DBG;
                else if (elig[MAIN_DMA]) state_d = MB_DMA;
                else if (elig[MAIN_CPU]) state_d = MB_CPU;
                else                     state_d = MB_IDLE;
            end
            default: state_d = MB_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        gnt    = mb_decode(state_q);
        win    = mb_decode(state_d);
        wait_o = wait_q;
    end
endmodule

// File: rtl/ram_eng_fsm.sv
module ram_eng_fsm
    import ram_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ENG-1:0] req,
    input  logic [NUM_ENG-1:0] clash,
    output logic [NUM_ENG-1:0] gnt,
    output logic [NUM_ENG-1:0] wait_o
);
    dp_state_t          state_q, state_d;
    logic [NUM_ENG-1:0] elig;
    logic [NUM_ENG-1:0] win;
    logic [NUM_ENG-1:0] wait_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DP_IDLE;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            wait_q  <= req & ~gnt & ~win;
        end
    end

    // Next state: an engine that clashes with the main-bus winner is skipped
    always_comb begin
        elig = req & ~gnt & ~clash;
        unique case (state_q)
            DP_IDLE, DP_ENGA, DP_ENGB: begin
                if (elig[ENG_A])      state_d = DP_ENGA;
                else if (elig[ENG_B]) state_d = DP_ENGB;
                else                  state_d = DP_IDLE;
            end
            default: state_d = DP_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        gnt    = dp_decode(state_q);
        win    = dp_decode(state_d);
        wait_o = wait_q;
    end
endmodule

// File: rtl/ram_region_arb.sv
module ram_region_arb
    import ram_arb_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int REGION_W = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_MAIN-1:0]        m_req,
    input  logic [NUM_MAIN*ADDR_W-1:0] m_addr,
    output logic [NUM_MAIN-1:0]        m_gnt,
    output logic [NUM_MAIN-1:0]        m_wait,
    input  logic [NUM_ENG-1:0]         e_req,
    input  logic [NUM_ENG*ADDR_W-1:0]  e_addr,
    output logic [NUM_ENG-1:0]         e_gnt,
    output logic [NUM_ENG-1:0]         e_wait
);
    logic [NUM_MAIN-1:0] m_win;
    logic [ADDR_W-1:0]   win_addr;
    logic                main_busy;
    logic [NUM_ENG-1:0]  same_rgn;
    logic [NUM_ENG-1:0]  clash;

    ram_main_fsm u_main (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (m_req),
        .win    (m_win),
        .gnt    (m_gnt),
        .wait_o (m_wait)
    );

    // Address of the master that will own the main bus next cycle
    always_comb begin
        win_addr = '0;
        for (int i = 0; i < NUM_MAIN; i++) begin
            if (m_win[i]) win_addr = m_addr[i*ADDR_W +: ADDR_W];
        end
    end

    assign main_busy = |m_win;

    for (genvar j = 0; j < NUM_ENG; j++) begin : g_cmp
        ram_region_cmp #(
            .ADDR_W   (ADDR_W),
            .REGION_W (REGION_W)
        ) u_cmp (
            .addr_a (win_addr),
            .addr_b (e_addr[j*ADDR_W +: ADDR_W]),
            .same   (same_rgn[j])
        );
        assign clash[j] = main_busy & same_rgn[j];
    end

    ram_eng_fsm u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (e_req),
        .clash  (clash),
        .gnt    (e_gnt),
        .wait_o (e_wait)
    );
endmodule

// File: rtl/ram_region_arb_chk.sv
module ram_region_arb_chk
    import ram_arb_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int REGION_W = 14
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_MAIN-1:0]        m_req,
    input logic [NUM_MAIN*ADDR_W-1:0] m_addr,
    input logic [NUM_MAIN-1:0]        m_gnt,
    input logic [NUM_MAIN-1:0]        m_wait,
    input logic [NUM_ENG-1:0]         e_req,
    input logic [NUM_ENG*ADDR_W-1:0]  e_addr,
    input logic [NUM_ENG-1:0]         e_gnt,
    input logic [NUM_ENG-1:0]         e_wait
);
    logic [NUM_MAIN*ADDR_W-1:0] m_addr_p;
    logic [NUM_ENG*ADDR_W-1:0]  e_addr_p;
    logic [ADDR_W-1:0]          m_g_addr, e_g_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_addr_p <= '0;
            e_addr_p <= '0;
        end else begin
            m_addr_p <= m_addr;
            e_addr_p <= e_addr;
        end
    end

    always_comb begin
        m_g_addr = '0;
        e_g_addr = '0;
        for (int i = 0; i < NUM_MAIN; i++)
            if (m_gnt[i]) m_g_addr = m_addr_p[i*ADDR_W +: ADDR_W];
        for (int j = 0; j < NUM_ENG; j++)
            if (e_gnt[j]) e_g_addr = e_addr_p[j*ADDR_W +: ADDR_W];
    end

    AST_MAIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(m_gnt)); // R9
    AST_ENG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(e_gnt)); // R9
    AST_NO_REGION_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        ((|m_gnt) && (|e_gnt)) |-> ((m_g_addr >> REGION_W) != (e_g_addr >> REGION_W))); // R4
    AST_DBG_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req[MAIN_DBG] && !m_gnt[MAIN_DBG]) |=> m_gnt[MAIN_DBG]); // R2
    AST_MAIN_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_gnt) |=> ((m_gnt & $past(m_gnt)) == '0)); // R6
    AST_ENG_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|e_gnt) |=> ((e_gnt & $past(e_gnt)) == '0)); // R6
    AST_MAIN_GNT_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_gnt) |-> ((m_gnt & ~$past(m_req)) == '0)); // R6
    AST_WAIT_NOT_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_wait & m_gnt) == '0) && ((e_wait & e_gnt) == '0)); // R7
endmodule

bind ram_region_arb ram_region_arb_chk #(
    .ADDR_W   (ADDR_W),
    .REGION_W (REGION_W)
) u_chk (.*);

// File: tb/ram_region_arb_tb.sv
module ram_region_arb_tb;
    localparam int AW = 18;
    localparam int RW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    m_req = '0;
    logic [3*AW-1:0] m_addr = '0;
    logic [2:0]    m_gnt, m_wait;
    logic [1:0]    e_req = '0;
    logic [2*AW-1:0] e_addr = '0;
    logic [1:0]    e_gnt, e_wait;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ram_region_arb #(.ADDR_W(AW), .REGION_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .m_req(m_req), .m_addr(m_addr), .m_gnt(m_gnt), .m_wait(m_wait),
        .e_req(e_req), .e_addr(e_addr), .e_gnt(e_gnt), .e_wait(e_wait)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] mk(int rgn, int off);
        return AW'((rgn << RW) | off);
    endfunction

    // Behavioural reference model, stepped on every rising edge
    logic [2:0] mg, mw;
    logic [1:0] eg, ew;

    always @(posedge clk or negedge rst_n) begin
        int mwin, ewin;
        logic [2:0] nmg, nmw;
        logic [1:0] neg, new_w;
        if (!rst_n) begin
            mg = '0; mw = '0; eg = '0; ew = '0;
        end else begin
            mwin = -1; ewin = -1;
            for (int i = 0; i < 3; i++)
                if (m_req[i] && !mg[i] && mwin < 0) mwin = i;
            for (int j = 0; j < 2; j++)
                if (e_req[j] && !eg[j] && ewin < 0) begin
                    if (!(mwin >= 0 &&
                          (m_addr[mwin*AW +: AW] >> RW) == (e_addr[j*AW +: AW] >> RW)))
                        ewin = j;
                end
            nmg = '0; nmw = '0; neg = '0; new_w = '0;
            for (int i = 0; i < 3; i++) begin
                nmg[i] = (i == mwin);
                nmw[i] = m_req[i] && !mg[i] && (i != mwin);
            end
            for (int j = 0; j < 2; j++) begin
                neg[j]   = (j == ewin);
                new_w[j] = e_req[j] && !eg[j] && (j != ewin);
            end
            mg = nmg; mw = nmw; eg = neg; ew = new_w;
        end
    end

    // Compare with the model on every clock
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 main grant vs model", 8'(m_gnt), 8'(mg));
            chk("R7 main wait vs model", 8'(m_wait), 8'(mw));
            chk("R5 engine grant vs model", 8'(e_gnt), 8'(eg));
            chk("R7 engine wait vs model", 8'(e_wait), 8'(ew));
            chk("R9 one-hot grants", 8'($onehot0(m_gnt) && $onehot0(e_gnt)), 8'd1);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit [2:0] mdone;
        bit [1:0] edone;
        mdone = '0; edone = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset main grant", 8'(m_gnt), 8'd0);
        chk("R1 reset waits", 8'({m_wait, e_wait}), 8'd0);
        chk("R1 reset engine grant", 8'(e_gnt), 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 8'({m_gnt, e_gnt, m_wait, e_wait}), 8'd0);

        // D1: regions differ across a boundary, both paths granted
        m_req = 3'b001; m_addr[0 +: AW] = mk(0, 16'h3FFF);
        e_req = 2'b01;  e_addr[0 +: AW] = mk(1, 0);
        @(negedge clk);
        chk("R3 R8 main granted", 8'(m_gnt), 8'h1);
        chk("R3 R8 engine A granted alongside", 8'(e_gnt), 8'h1);
        chk("R7 no wait without conflict", 8'({m_wait, e_wait}), 8'd0);
        @(negedge clk);
        chk("R6 no regrant of held request", 8'({m_gnt, e_gnt}), 8'd0);
        m_req = '0; e_req = '0;
        @(negedge clk);

        // D2: same region, different low bits, main wins
        m_req = 3'b001; m_addr[0 +: AW] = mk(1, 0);
        e_req = 2'b01;  e_addr[0 +: AW] = mk(1, 16'h3FFC);
        @(negedge clk);
        chk("R4 R8 main wins clash", 8'(m_gnt), 8'h1);
        chk("R4 engine blocked", 8'(e_gnt), 8'h0);
        chk("R7 engine waits", 8'(e_wait), 8'h1);
        @(negedge clk);
        chk("R4 engine granted after main", 8'(e_gnt), 8'h1);
        chk("R7 wait cleared on grant", 8'({m_wait, e_wait}), 8'd0);
        m_req = '0;
        @(negedge clk);
        chk("R6 engine one cycle", 8'(e_gnt), 8'h0);
        e_req = '0;
        @(negedge clk);

        // D3: all main masters at once
        m_req = 3'b111;
        m_addr = {mk(3, 0), mk(3, 4), mk(3, 8)};
        @(negedge clk);
        chk("R2 debug first", 8'(m_gnt), 8'h1);
        chk("R7 losers wait", 8'(m_wait), 8'h6);
        m_req = 3'b110;
        @(negedge clk);
        chk("R2 DMA second", 8'(m_gnt), 8'h2);
        chk("R7 CPU still waits", 8'(m_wait), 8'h4);
        m_req = 3'b100;
        @(negedge clk);
        chk("R2 CPU third", 8'(m_gnt), 8'h4);
        m_req = 3'b000;
        @(negedge clk);
        chk("R6 main idle", 8'(m_gnt), 8'h0);

        // D4: A clashes with DMA, B in another region proceeds
        m_req = 3'b010; m_addr[AW +: AW] = mk(2, 12);
        e_req = 2'b11;  e_addr = {mk(3, 0), mk(2, 64)};
        @(negedge clk);
        chk("R5 DMA granted", 8'(m_gnt), 8'h2);
        chk("R5 B granted while A blocked", 8'(e_gnt), 8'h2);
        chk("R5 A waits", 8'(e_wait), 8'h1);
        m_req = '0; e_req = 2'b01;
        @(negedge clk);
        chk("R5 A granted next", 8'(e_gnt), 8'h1);
        e_req = '0;
        @(negedge clk);
        chk("R6 engines idle", 8'(e_gnt), 8'h0);

        // Random phase: two regions only, so clashes are frequent
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            for (int i = 0; i < 3; i++) begin
                if (m_req[i] && !mdone[i]) begin
                    if (mg[i]) mdone[i] = 1'b1;
                end else begin
                    mdone[i] = 1'b0;
                    m_req[i] = ($urandom % 3) == 0;
                    m_addr[i*AW +: AW] = mk($urandom % 2, $urandom % 16384);
                end
            end
            for (int j = 0; j < 2; j++) begin
                if (e_req[j] && !edone[j]) begin
                    if (eg[j]) edone[j] = 1'b1;
                end else begin
                    edone[j] = 1'b0;
                    e_req[j] = ($urandom % 2) == 0;
                    e_addr[j*AW +: AW] = mk($urandom % 2, $urandom % 16384);
                end
            end
        end
        m_req = '0; e_req = '0;
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule